// File: doc/BRIEF.md
# Receive Buffer Flush Latency Timer

This block decides when the bytes held in one channel's receive buffer are handed to the upstream packet builder, so that small amounts of received data do not sit indefinitely waiting for a packet to fill. It watches the buffer's byte count and a data-arrival pulse. It counts 1 ms ticks against a programmable latency while the buffer holds data. It raises a flush request when that count runs out, when the buffer holds a whole packet, or on every 125 us microframe tick when the latency is programmed to zero.

The packet builder answers the request with a one-cycle acknowledge. The acknowledge drops the request and restarts the timer. The request also carries a flag that says whether a full packet is waiting or only a short one. The latency is written through a small configuration port. A new value is held in a configuration register and is only adopted by the running timer at its next restart, so a count already in progress is never disturbed.

Top module: `rx_flush_timer`

## Requirements
- R1: After reset, `flush_req` and `flush_full` are 0 and the configured latency is 16 ms. With no writes, a non-empty buffer therefore raises a request on the 16th 1 ms tick.
- R2: The timer counts `tick_1ms` pulses only while the buffer is occupied and no request is pending. Ticks that arrive while the buffer is empty are not counted. `flush_req` rises in the cycle after the tick that brings the count to the active latency.
- R3: Once raised, `flush_req` stays high until `flush_ack` is seen. The cycle after an acknowledge, `flush_req` is 0 and the count restarts from zero.
- R4: A byte count of at least `PKT_BYTES` (512) raises `flush_req` in the next cycle with `flush_full` = 1, whatever the timer holds.
- R5: With an active latency of 0, every `tick_uframe` pulse while the buffer is occupied raises `flush_req` in the next cycle. With a non-zero latency, microframe ticks have no effect.
- R6: An empty buffer never raises a request, including when the latency is 0.
- R7: A latency written with `lat_wr` becomes active only at the next timer restart, which is an acknowledge or a cycle with an empty buffer. While a count runs, the previous value governs it.
- R8: A written latency above 256 is stored as 256.
- R9: A `data_arrive` pulse marks the buffer as occupied in its own cycle, even while `buf_count` still reads 0.
- R10: `flush_full` is 0 on a request raised only by the timer or the microframe tick with fewer than 512 bytes buffered. It goes to 1 if the buffer reaches 512 bytes while the request is pending. It clears on acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_count | input | 12 | Bytes currently held in the receive buffer |
| data_arrive | input | 1 | Pulse: a byte is being written into the buffer this cycle |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| tick_uframe | input | 1 | One-cycle pulse every 125 us microframe |
| lat_wr | input | 1 | Write strobe for the latency setting |
| lat_wdata | input | 9 | Latency in ms to be written (saturated at 256) |
| flush_ack | input | 1 | Packet builder accepts the pending flush |
| flush_req | output | 1 | Flush request to the packet builder |
| flush_full | output | 1 | A full packet is available with the pending request |

## Verification
Timer expiry and the buffer reaching a full packet can land in the same clock cycle. In that case the request must come out marked full rather than short. The bench runs a short latency down to its last tick, then raises the byte count to 512 in exactly the cycle that carries that final tick, and expects both `flush_req` and `flush_full` high one cycle later. A second coincidence pairs an acknowledge with a still-full buffer. It is judged by seeing the request drop for one cycle and return with the full flag.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // Reasons a flush may be requested in a given cycle
  typedef struct packed {
    logic full;     // a whole packet is buffered
    logic expired;  // millisecond timeout ran out
    logic uframe;   // zero-latency mode, microframe boundary
  } rxf_cause_t;

  function automatic logic rxf_any(input rxf_cause_t c);
    return c.full | c.expired | c.uframe;
  endfunction

endpackage

// File: rtl/rxf_lat_reg.sv
module rxf_lat_reg #(
  parameter int LAT_W   = 9,
  parameter int MAX_LAT = 256,
  parameter int DEF_LAT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [LAT_W-1:0] wdata,
  input  logic             restart,
  output logic [LAT_W-1:0] act_lat
);

  localparam logic [LAT_W-1:0] MAX_V = LAT_W'(MAX_LAT);
  localparam logic [LAT_W-1:0] DEF_V = LAT_W'(DEF_LAT);

  logic [LAT_W-1:0] cfg_q;
  logic [LAT_W-1:0] wsat;

  assign wsat = (wdata > MAX_V) ? MAX_V : wdata;

  // Configured value, written by the control side
  always_ff @(posedge clk) begin
    if (rst)     cfg_q <= DEF_V;
    else if (wr) cfg_q <= wsat;
  end

  // Value governing the running count, adopted only at a restart
  always_ff @(posedge clk) begin
    if (rst)          act_lat <= DEF_V;
    else if (restart) act_lat <= cfg_q;
  end

endmodule

// File: rtl/rxf_ms_timer.sv
module rxf_ms_timer #(
  parameter int LAT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic             tick,
  input  logic [LAT_W-1:0] act_lat,
  output logic             expired
);

  logic [LAT_W-1:0] cnt_q;
  logic [LAT_W:0]   cnt_inc;
  logic             lat_nz;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign lat_nz  = (act_lat != '0);
  assign expired = run && tick && lat_nz && (cnt_inc >= {1'b0, act_lat});

  always_ff @(posedge clk) begin
    if (rst || restart)
      cnt_q <= '0;
    else if (run && tick && (cnt_q < act_lat))
      cnt_q <= cnt_inc[LAT_W-1:0];
  end

endmodule

// File: rtl/rxf_req_ctrl.sv
module rxf_req_ctrl
  import rxf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       grant,
  input  rxf_cause_t cause,
  output logic       req,
  output logic       full
);

  always_ff @(posedge clk) begin
    if (rst || grant) begin
      req  <= 1'b0;
      full <= 1'b0;
    end else if (!req) begin
      req  <= rxf_any(cause);
      full <= cause.full;
    end else if (cause.full) begin
      full <= 1'b1;
    end
  end

endmodule

// File: rtl/rx_flush_timer.sv
module rx_flush_timer
  import rxf_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int PKT_BYTES = 512,
  parameter int MAX_LAT   = 256,
  parameter int DEF_LAT   = 16
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [$clog2(BUF_BYTES+1)-1:0]   buf_count,
  input  logic                             data_arrive,
  input  logic                             tick_1ms,
  input  logic                             tick_uframe,
  input  logic                             lat_wr,
  input  logic [$clog2(MAX_LAT+1)-1:0]     lat_wdata,
  input  logic                             flush_ack,
  output logic                             flush_req,
  output logic                             flush_full
);

  localparam int CNT_W = $clog2(BUF_BYTES+1);
  localparam int LAT_W = $clog2(MAX_LAT+1);
  localparam logic [CNT_W-1:0] PKT_V = CNT_W'(PKT_BYTES);

  logic             occupied;
  logic             full_now;
  logic             grant;
  logic             restart;
  logic             expired;
  logic [LAT_W-1:0] act_lat;
  rxf_cause_t       cause;

  assign occupied = (buf_count != '0) || data_arrive;
  assign full_now = (buf_count >= PKT_V);
  assign grant    = flush_req && flush_ack;
  assign restart  = grant || !occupied;

  rxf_lat_reg #(
    .LAT_W  (LAT_W),
    .MAX_LAT(MAX_LAT),
    .DEF_LAT(DEF_LAT)
  ) u_lat (
    .clk    (clk),
    .rst    (rst),
    .wr     (lat_wr),
    .wdata  (lat_wdata),
    .restart(restart),
    .act_lat(act_lat)
  );

  rxf_ms_timer #(
    .LAT_W(LAT_W)
  ) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .restart(restart),
    .run    (occupied && !flush_req),
    .tick   (tick_1ms),
    .act_lat(act_lat),
    .expired(expired)
  );

  always_comb begin
    cause.full    = full_now;
    cause.expired = expired;
    cause.uframe  = (act_lat == '0) && tick_uframe && occupied;
  end

  rxf_req_ctrl u_req (
    .clk  (clk),
    .rst  (rst),
    .grant(grant),
    .cause(cause),
    .req  (flush_req),
    .full (flush_full)
  );

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int CNT_W     = 12,
  parameter int LAT_W     = 9,
  parameter int PKT_BYTES = 512
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] buf_count,
  input logic             data_arrive,
  input logic             tick_uframe,
  input logic             flush_ack,
  input logic             flush_req,
  input logic             flush_full,
  input logic [LAT_W-1:0] act_lat
);

  // R3: request holds until acknowledged
  assert_hold_until_ack_R3: assert property (@(posedge clk) disable iff (rst)
    flush_req && !flush_ack |=> flush_req);

  // R3: acknowledge drops the request for the next cycle
  assert_ack_drops_R3: assert property (@(posedge clk) disable iff (rst)
    flush_req && flush_ack |=> !flush_req && !flush_full);

  // R4: a full packet raises a full request next cycle
  assert_full_bypass_R4: assert property (@(posedge clk) disable iff (rst)
    !flush_req && (buf_count >= CNT_W'(PKT_BYTES)) |=> flush_req && flush_full);

  // R6: an empty buffer never starts a request
  assert_empty_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !flush_req && (buf_count == '0) && !data_arrive |=> !flush_req);

  // R5: zero latency flushes on each occupied microframe
  assert_zero_lat_uframe_R5: assert property (@(posedge clk) disable iff (rst)
    !flush_req && (act_lat == '0) && tick_uframe && ((buf_count != '0) || data_arrive)
    |=> flush_req);

  // R10: the full flag only accompanies a request
  assert_full_with_req_R10: assert property (@(posedge clk) disable iff (rst)
    flush_full |-> flush_req);

endmodule

bind rx_flush_timer rxf_checker #(
  .CNT_W    (CNT_W),
  .LAT_W    (LAT_W),
  .PKT_BYTES(PKT_BYTES)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .buf_count  (buf_count),
  .data_arrive(data_arrive),
  .tick_uframe(tick_uframe),
  .flush_ack  (flush_ack),
  .flush_req  (flush_req),
  .flush_full (flush_full),
  .act_lat    (act_lat)
);

// File: tb/rx_flush_timer_test.sv
`timescale 1ns/1ps
module rx_flush_timer_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] buf_count = '0;
  logic        data_arrive = 1'b0;
  logic        tick_1ms = 1'b0;
  logic        tick_uframe = 1'b0;
  logic        lat_wr = 1'b0;
  logic [8:0]  lat_wdata = '0;
  logic        flush_ack = 1'b0;
  logic        flush_req;
  logic        flush_full;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  rx_flush_timer uut (
    .clk        (clk),
    .rst        (rst),
    .buf_count  (buf_count),
    .data_arrive(data_arrive),
    .tick_1ms   (tick_1ms),
    .tick_uframe(tick_uframe),
    .lat_wr     (lat_wr),
    .lat_wdata  (lat_wdata),
    .flush_ack  (flush_ack),
    .flush_req  (flush_req),
    .flush_full (flush_full)
  );

  // {count[11:0], arrive, ms, uframe, ack, exp_req, exp_full}
  localparam int NV = 12;
  localparam logic [17:0] VEC [NV] = '{
    {12'd0,   1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R6 empty, uframe
    {12'd0,   1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},  // R9 arrival counts
    {12'd3,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R3 ack
    {12'd3,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R5 no uframe
    {12'd3,   1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},  // R5 uframe
    {12'd3,   1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},  // R3 held
    {12'd512, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R10 upgrade
    {12'd512, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R3 ack while full
    {12'd512, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R4 re-raise
    {12'd0,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R3 ack
    {12'd0,   1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R6 empty, ticks
    {12'd700, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}   // R4 above packet
  };

  task automatic check(input string tag, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic pulse_ms(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_1ms = 1'b1;
      @(negedge clk) tick_1ms = 1'b0;
    end
  endtask

  task automatic pulse_uf(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_uframe = 1'b1;
      @(negedge clk) tick_uframe = 1'b0;
    end
  endtask

  task automatic write_lat(input logic [8:0] v);
    @(negedge clk) begin lat_wr = 1'b1; lat_wdata = v; end
    @(negedge clk) lat_wr = 1'b0;
  endtask

  task automatic ack_once();
    @(negedge clk) flush_ack = 1'b1;
    @(negedge clk) flush_ack = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  initial begin
    do_reset();
    check("R1 reset req", flush_req, 1'b0);
    check("R1 reset full", flush_full, 1'b0);

    // Default 16 ms latency, timer-only request
    buf_count = 12'd5;
    pulse_ms(15);
    check("R1 before 16th tick", flush_req, 1'b0);
    pulse_ms(1);
    check("R2 16th tick req", flush_req, 1'b1);
    check("R10 timer-only full", flush_full, 1'b0);

    // Ticks while empty are not counted
    do_reset();
    buf_count = 12'd0;
    pulse_ms(20);
    check("R6 empty ticks", flush_req, 1'b0);
    buf_count = 12'd5;
    pulse_ms(15);
    check("R2 empty ticks ignored", flush_req, 1'b0);
    pulse_ms(1);
    check("R2 expiry after refill", flush_req, 1'b1);

    // New latency adopted only at restart
    write_lat(9'd3);
    check("R3 held during write", flush_req, 1'b1);
    ack_once();
    check("R3 ack clears", flush_req, 1'b0);
    pulse_ms(2);
    check("R7 new value 3, 2 ticks", flush_req, 1'b0);
    pulse_ms(1);
    check("R7 new value 3, 3rd tick", flush_req, 1'b1);
    ack_once();
    pulse_ms(1);
    write_lat(9'd10);
    pulse_ms(2);
    check("R7 old value governs", flush_req, 1'b1);
    ack_once();
    pulse_uf(3);
    check("R5 uframe ignored nonzero", flush_req, 1'b0);
    pulse_ms(9);
    check("R7 value 10, 9 ticks", flush_req, 1'b0);
    pulse_ms(1);
    check("R7 value 10, 10th tick", flush_req, 1'b1);

    // Saturation of large writes
    buf_count = 12'd0;
    ack_once();
    write_lat(9'd300);
    @(negedge clk);
    buf_count = 12'd5;
    pulse_ms(255);
    check("R8 saturated 255 ticks", flush_req, 1'b0);
    pulse_ms(1);
    check("R8 saturated 256th tick", flush_req, 1'b1);

    // Expiry and full packet in the same cycle
    buf_count = 12'd0;
    ack_once();
    write_lat(9'd2);
    @(negedge clk);
    buf_count = 12'd5;
    pulse_ms(1);
    @(negedge clk) begin tick_1ms = 1'b1; buf_count = 12'd512; end
    @(negedge clk) tick_1ms = 1'b0;
    check("R4 coincident req", flush_req, 1'b1);
    check("R10 coincident full", flush_full, 1'b1);

    // Vector table in zero-latency mode
    do_reset();
    buf_count = 12'd0;
    write_lat(9'd0);
    @(negedge clk);
    for (int v = 0; v < NV; v++) begin
      buf_count   = VEC[v][17:6];
      data_arrive = VEC[v][5];
      tick_1ms    = VEC[v][4];
      tick_uframe = VEC[v][3];
      flush_ack   = VEC[v][2];
      @(negedge clk);
      check($sformatf("R5 vec %0d req", v), flush_req, VEC[v][1]);
      check($sformatf("R10 vec %0d full", v), flush_full, VEC[v][0]);
    end
    data_arrive = 1'b0;
    tick_1ms    = 1'b0;
    tick_uframe = 1'b0;
    flush_ack   = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 50000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule